// File: doc/BRIEF.md
# Pipelined Integer Multiply Unit with Upper-Word Variants

This block is the multiply engine of a scalar integer core. Each request carries two 32-bit operands and a 2-bit function code. From the full 64-bit product it returns a single 32-bit word: either the lower word, or the upper word computed under one of three signedness readings of the operands.

Both operands are first widened by one bit, using sign or zero fill as the function code dictates. The two 33-bit values are then multiplied as signed numbers, and the wanted 32-bit slice is kept. The result is always ready a fixed two clock edges after the request is taken. A new request can be taken on every cycle, so the issue logic only has to count cycles to know when a result is due.

Top module: `imul_unit`

## Requirements
- R1: The function code `fn` selects the operation: 2'b00 returns the lower product word, 2'b01 the upper word with both operands signed, 2'b10 the upper word with `opA` signed and `opB` unsigned, and 2'b11 the upper word with both operands unsigned.
- R2: With `fn` = 2'b00, `result` equals bits [31:0] of `opA`×`opB`. These bits do not depend on whether the operands are read as signed or unsigned.
- R3: With `fn` = 2'b01, `result` is bits [63:32] of the two's-complement product. The sign carries into the upper word, so 0x80000000×0x80000000 gives 0x40000000 and 0xFFFFFFFF×2 gives 0xFFFFFFFF.
- R4: With `fn` = 2'b11, `result` is bits [63:32] of the unsigned product, so 0xFFFFFFFF×0xFFFFFFFF gives 0xFFFFFFFE.
- R5: With `fn` = 2'b10, `result` is bits [63:32] of signed `opA` times unsigned `opB`, so 0xFFFFFFFF×0xFFFFFFFF gives 0xFFFFFFFF.
- R6: A request is taken on a rising edge where `inValid` and `inReady` are both high. After the second rising edge that follows, `outValid` is high for exactly one cycle and `result` holds that request's answer.
- R7: `inReady` is high on every cycle outside reset, and requests on consecutive cycles give results on consecutive cycles, in the order they were issued.
- R8: While `rst` is high, `inReady` is low, and `outValid` is low after the first rising edge of the reset.
- R9: A cycle with `inValid` low produces `outValid` low two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A request is present on `fn`, `opA`, `opB` |
| inReady | output | 1 | The unit can take a request this cycle |
| fn | input | 2 | Function code (see R1) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | `result` holds a finished answer |
| result | output | 32 | Selected 32-bit word of the product |

## Verification
The assertions watch, on every cycle, the two-edge latency of the valid flag, the fact that idle cycles stay idle, and the reset behaviour. On each valid lower-word result, they compare the output against a plain 32-bit product of the operands from two cycles earlier. They also check the sign of signed upper results, the bound on unsigned upper results, and that mixed results are non-negative when `opA` is non-negative. Exact upper-word values, including the three extreme operand pairs, can only be confirmed by the bench. It drives a table of known vectors and a pseudo-random stream back to back, and compares each result against a separate 64-bit reference model.

// File: rtl/imul_pkg.sv
package imul_pkg;

  localparam int unsigned OP_W = 32;

  typedef enum logic [1:0] {
    FN_LOW = 2'b00,
    FN_HSS = 2'b01,
    FN_HSU = 2'b10,
    FN_HUU = 2'b11
  } mulFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOperands;
    logic loadResult;
    logic signA;
    logic signB;
    logic takeHigh;
  } mulStrobe_t;

endpackage

// File: rtl/imul_ctrl.sv
module imul_ctrl
  import imul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] fn,
  output logic       inReady,
  output logic       outValid,
  output mulStrobe_t strobe
);

  localparam int unsigned STAGES = 2;

  logic [STAGES-1:0] validPipe;
  logic              accept;

  assign inReady = ~rst;
  assign accept  = inValid & inReady;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[STAGES-2:0], accept};
  end

  assign outValid = validPipe[STAGES-1];

  always_comb begin
    strobe.loadOperands = accept;
    strobe.loadResult   = validPipe[0];
    strobe.signA        = (fn == FN_HSS) || (fn == FN_HSU);
    strobe.signB        = (fn == FN_HSS);
    strobe.takeHigh     = (fn != FN_LOW);
  end

  // R6
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> ##1 outValid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !outValid);

  // R7
  ready_high_chk: assert property (@(posedge clk)
    !rst |-> inReady);

endmodule

// File: rtl/imul_datapath.sv
module imul_datapath
  import imul_pkg::*;
#(
  parameter int unsigned W = OP_W
)(
  input  logic         clk,
  input  mulStrobe_t   strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result
);

  localparam int unsigned EXT_W  = W + 1;
  localparam int unsigned PROD_W = 2 * W;

  logic [EXT_W-1:0]  extA, extB;
  logic              highSel;
  logic [PROD_W-1:0] prod;

  // stage 1: widen operands with sign or zero fill
  always_ff @(posedge clk) begin
    if (strobe.loadOperands) begin
      extA    <= {strobe.signA & opA[W-1], opA};
      extB    <= {strobe.signB & opB[W-1], opB};
      highSel <= strobe.takeHigh;
    end
  end

  // signed 33x33 product, the low 64 bits carry every variant
  assign prod = PROD_W'($signed(extA) * $signed(extB));

  // stage 2: keep the selected word
  always_ff @(posedge clk) begin
    if (strobe.loadResult)
      result <= highSel ? prod[PROD_W-1:W] : prod[W-1:0];
  end

endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  input  logic [1:0]  fn,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        outValid,
  output logic [31:0] result
);

  mulStrobe_t strobe;

  imul_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .fn       (fn),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  imul_datapath #(.W(OP_W)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

  // R2
  low_word_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(fn, 2) == FN_LOW)
      |-> result == 32'($past(opA, 2) * $past(opB, 2)));

  // R3
  signed_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(fn, 2) == FN_HSS && $past(opA, 2) != 0 && $past(opB, 2) != 0)
      |-> result[31] == ($past(opA[31], 2) ^ $past(opB[31], 2)));

  // R4
  unsigned_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(fn, 2) == FN_HUU) |-> result <= $past(opA, 2));

  // R5
  mixed_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(fn, 2) == FN_HSU && !$past(opA[31], 2)) |-> !result[31]);

endmodule

// File: tb/tb_imul_unit.sv
module tb_imul_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        inReady;
  logic [1:0]  fn;
  logic [31:0] opA, opB;
  logic        outValid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  imul_unit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .fn(fn), .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  // {fn, opA, opB, expected}
  localparam int NV = 14;
  localparam logic [97:0] VECS [0:NV-1] = '{
    {2'b00, 32'h00000003, 32'h00000005, 32'h0000000F},  // R2
    {2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001},  // R2
    {2'b01, 32'h80000000, 32'h80000000, 32'h40000000},  // R3
    {2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE},  // R4
    {2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},  // R5
    {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},  // R3
    {2'b01, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF},  // R3
    {2'b11, 32'hFFFFFFFF, 32'h00000002, 32'h00000001},  // R4
    {2'b10, 32'h00000002, 32'hFFFFFFFF, 32'h00000001},  // R5
    {2'b01, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h3FFFFFFF},  // R3
    {2'b10, 32'h80000000, 32'h80000000, 32'hC0000000},  // R5
    {2'b00, 32'h80000000, 32'h80000000, 32'h00000000},  // R2
    {2'b01, 32'h00010000, 32'hFFFF0000, 32'hFFFFFFFF},  // R3
    {2'b11, 32'h00010000, 32'h00010000, 32'h00000001}   // R4
  };

  localparam int QMAX = 64;
  logic [1:0]  qFn  [0:QMAX-1];
  logic [31:0] qA   [0:QMAX-1];
  logic [31:0] qB   [0:QMAX-1];
  logic [31:0] qExp [0:QMAX-1];

  function automatic logic [31:0] refMul(logic [1:0] f, logic [31:0] a, logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    logic [63:0] p;
    case (f)
      2'b01:   p = 64'(sa * sb);
      2'b10:   p = 64'(sa * ub);
      default: p = 64'(ua * ub);
    endcase
    return (f == 2'b00) ? p[31:0] : p[63:32];
  endfunction

  function automatic string reqOf(logic [1:0] f);
    case (f)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // issue n queued requests back to back and check each answer two edges later (R7)
  task automatic runStream(int n);
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check(outValid == 1'b1, "R7", "outValid in stream", 32'(outValid), 32'd1);
        check(result == qExp[i-2], reqOf(qFn[i-2]), "result", result, qExp[i-2]);
      end
      if (i < n) begin
        inValid = 1'b1; fn = qFn[i]; opA = qA[i]; opB = qB[i];
      end else begin
        inValid = 1'b0;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog: actual %h expected %h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] seed;
    rst = 1'b1; inValid = 1'b0; fn = 2'b00; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(inReady == 1'b0, "R8", "inReady in reset", 32'(inReady), 32'd0);
    check(outValid == 1'b0, "R8", "outValid in reset", 32'(outValid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(inReady == 1'b1, "R7", "inReady after reset", 32'(inReady), 32'd1);

    // table of known vectors, back to back (R1..R5, R7)
    for (int i = 0; i < NV; i++) begin
      {qFn[i], qA[i], qB[i], qExp[i]} = VECS[i];
    end
    runStream(NV);

    // R9: idle cycles stay idle
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R9", "outValid after idle", 32'(outValid), 32'd0);

    // R6: single request latency
    @(negedge clk);
    inValid = 1'b1; fn = 2'b01; opA = 32'hFFFFFFFE; opB = 32'h00000003;
    @(negedge clk);
    inValid = 1'b0; fn = 2'b00; opA = '0; opB = '0;
    check(outValid == 1'b0, "R6", "outValid after one edge", 32'(outValid), 32'd0);
    @(negedge clk);
    check(outValid == 1'b1, "R6", "outValid after two edges", 32'(outValid), 32'd1);
    check(result == 32'hFFFFFFFF, "R6", "result after two edges", result, 32'hFFFFFFFF);
    @(negedge clk);
    check(outValid == 1'b0, "R6", "outValid one-cycle pulse", 32'(outValid), 32'd0);

    // pseudo-random stream against the 64-bit reference (R1)
    seed = 32'h1234ABCD;
    for (int i = 0; i < 48; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      qA[i] = seed ^ {seed[15:0], seed[31:16]};
      seed = seed * 32'd1664525 + 32'd1013904223;
      qB[i] = (seed[3:0] == 4'h0) ? 32'h80000000 : seed;
      qFn[i] = seed[29:28];
      qExp[i] = refMul(qFn[i], qA[i], qB[i]);
    end
    runStream(48);

    // R8: reset mid-stream clears outValid
    @(negedge clk);
    inValid = 1'b1; fn = 2'b00; opA = 32'd7; opB = 32'd9;
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid after reset edge", 32'(outValid), 32'd0);
    check(inReady == 1'b0, "R8", "inReady during reset", 32'(inReady), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end

endmodule